// File: doc/BRIEF.md
# Extend-Then-Right-Shift Barrel Shifter

A combinational word shifter for a single-cycle datapath. It performs logical left shift, logical right shift, arithmetic right shift and rotate right on a W-bit word (W = 32 by default) by an amount of log2(W) bits. All four operations share one right-only multiplexer network.

First, the input word is widened to 2W-1 bits. The filler depends on the operation: zeros, sign copies, or the low bits of the word for rotation. The widened word then passes through log2(W) cascaded stages. Each stage either passes its input or shifts it right by a power of two, taking the largest step first, and each stage drops the bits that can no longer reach the output. The low W bits of the last stage are the result.

A left shift puts the word at the top of the widened value and drives the stages with the bitwise complement of the amount. A left shift by k is therefore a right shift by W-1-k. Rotate left is not a hardware operation: software issues rotate right by (W - r) mod W.

Top module: `shf_barrel`

## Requirements
- R1: With op_i = 2'b00 (logical left), res_o equals data_i shifted left by amt_i, with zeros entering at bit 0.
- R2: With op_i = 2'b01 (logical right), res_o equals data_i shifted right by amt_i, with zeros entering at the top bit.
- R3: With op_i = 2'b10 (arithmetic right), res_o equals data_i shifted right by amt_i, with copies of data_i[W-1] entering at the top bit.
- R4: With op_i = 2'b11 (rotate right), res_o[i] equals data_i[(i + amt_i) mod W] for every bit i.
- R5: An amount of zero returns data_i unchanged under every operation.
- R6: A logical left shift by W-1 gives data_i[0] in bit W-1 and zeros in every other bit.
- R7: An arithmetic right shift by W-1 gives data_i[W-1] in every bit.
- R8: Rotate right by (W - r) mod W gives the same result as rotating data_i left by r, for every r from 0 to W-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | W | Word to shift |
| amt_i | input | log2(W) | Shift or rotate amount |
| op_i | input | 2 | Operation: 00 left logical, 01 right logical, 10 right arithmetic, 11 rotate right |
| res_o | output | W | Shifted word |

## Verification
The bench builds the block with the default W = 32. At this size a five-bit amount covers every possible distance, so every operation is swept over all 32 amounts for several data patterns. The patterns include sign-set and sign-clear words, a single low bit and alternating bits. These patterns reach both ends of each stage's select: the complemented amount path for left shifts, and the widest sign and wrap fills at amount 31.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [1:0] {
    SHF_SLL = 2'b00,
    SHF_SRL = 2'b01,
    SHF_SRA = 2'b10,
    SHF_ROR = 2'b11
  } shf_op_e;
endpackage

// File: rtl/shf_extend.sv
module shf_extend
  import shf_pkg::*;
#(
  parameter int W = 32,
  localparam int EW = 2 * W - 1
) (
  input  logic [W-1:0]  data_i,
  input  shf_op_e       op_i,
  output logic [EW-1:0] ext_o
);
  always_comb begin
    unique case (op_i)
      SHF_SLL: ext_o = {data_i, {(W-1){1'b0}}};
      SHF_SRL: ext_o = {{(W-1){1'b0}}, data_i};
      SHF_SRA: ext_o = {{(W-1){data_i[W-1]}}, data_i};
      default: ext_o = {data_i[W-2:0], data_i};
    endcase
  end
endmodule

// File: rtl/shf_amt_map.sv
module shf_amt_map #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] amt_i,
  input  logic          left_i,
  output logic [AW-1:0] ctl_o
);
  // left shift by k == right shift by (2^AW - 1 - k)
  assign ctl_o = left_i ? ~amt_i : amt_i;
endmodule

// File: rtl/shf_stage.sv
module shf_stage #(
  parameter int IN_W = 63,
  parameter int SH   = 16,
  localparam int OUT_W = IN_W - SH
) (
  input  logic [IN_W-1:0]  in_i,
  input  logic             sel_i,
  output logic [OUT_W-1:0] out_o
);
  assign out_o = sel_i ? in_i[IN_W-1:SH] : in_i[OUT_W-1:0];
endmodule

// File: rtl/shf_barrel.sv
module shf_barrel
  import shf_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]         data_i,
  input  logic [$clog2(W)-1:0] amt_i,
  input  logic [1:0]           op_i,
  output logic [W-1:0]         res_o
);
  localparam int AW = $clog2(W);
  localparam int EW = 2 * W - 1;

  shf_op_e       op;
  logic [EW-1:0] ext;
  logic [AW-1:0] ctl;

  assign op = shf_op_e'(op_i);

  shf_extend #(.W(W)) u_ext (
    .data_i(data_i),
    .op_i  (op),
    .ext_o (ext)
  );

  shf_amt_map #(.AW(AW)) u_amt (
    .amt_i (amt_i),
    .left_i(op == SHF_SLL),
    .ctl_o (ctl)
  );

  // largest step first; each stage drops bits that cannot reach the output
  for (genvar b = AW - 1; b >= 0; b--) begin : g_stage
    localparam int IW = W + (2 ** (b + 1)) - 1;
    localparam int OW = W + (2 ** b) - 1;
    logic [IW-1:0] src;
    logic [OW-1:0] q;
    if (b == AW - 1) begin : g_first
      assign src = ext;
    end else begin : g_next
      assign src = g_stage[b+1].q;
    end
    shf_stage #(.IN_W(IW), .SH(2 ** b)) u_stage (
      .in_i (src),
      .sel_i(ctl[b]),
      .out_o(q)
    );
  end

  assign res_o = g_stage[0].q;
endmodule

// File: rtl/shf_barrel_chk.sv
module shf_barrel_chk #(
  parameter int W = 32
) (
  input logic [W-1:0]         data_i,
  input logic [$clog2(W)-1:0] amt_i,
  input logic [1:0]           op_i,
  input logic [W-1:0]         res_o
);
  logic [2*W-1:0]       dbl;
  logic signed [W-1:0]  sra_ref;

  assign dbl     = {data_i, data_i} >> amt_i;
  assign sra_ref = $signed(data_i) >>> amt_i;

  always_comb begin
    // R1
    sll_ref_chk: assert (op_i != 2'b00 || res_o == (data_i << amt_i))
      else $error("sll mismatch");
    // R2
    srl_ref_chk: assert (op_i != 2'b01 || res_o == (data_i >> amt_i))
      else $error("srl mismatch");
    // R3
    sra_ref_chk: assert (op_i != 2'b10 || res_o == sra_ref)
      else $error("sra mismatch");
    // R4
    ror_ref_chk: assert (op_i != 2'b11 || res_o == dbl[W-1:0])
      else $error("ror mismatch");
    // R5
    zero_amt_chk: assert (amt_i != '0 || res_o == data_i)
      else $error("zero amount changed data");
    // R7
    sra_full_chk: assert (!(op_i == 2'b10 && amt_i == '1) || res_o == {W{data_i[W-1]}})
      else $error("sra by max not sign fill");
  end
endmodule

bind shf_barrel shf_barrel_chk #(.W(W)) u_chk (
  .data_i(data_i),
  .amt_i (amt_i),
  .op_i  (op_i),
  .res_o (res_o)
);

// File: tb/shf_barrel_test.sv
module shf_barrel_test;
  localparam int W  = 32;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [W-1:0]  data;
  logic [AW-1:0] amt;
  logic [1:0]    op;
  logic [W-1:0]  res;
  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [W-1:0] pats [5] = '{32'h8000_0001, 32'h7FFF_FFFE, 32'h0000_0001,
                             32'hA5A5_5A5A, 32'hF0E1_D2C3};

  always #2.5 clk = ~clk;

  shf_barrel #(.W(W)) uut (
    .data_i(data),
    .amt_i (amt),
    .op_i  (op),
    .res_o (res)
  );

  task automatic apply(input logic [1:0] o, input logic [W-1:0] d, input int a);
    @(negedge clk);
    op = o; data = d; amt = AW'(a);
    #1;
  endtask

  task automatic check(input string req, input logic [W-1:0] exp);
    n_chk++;
    if (res !== exp) begin
      n_bad++;
      $display("FAIL %s op=%0d amt=%0d data=%h got=%h exp=%h", req, op, amt, data, res, exp);
    end
  endtask

  function automatic logic [W-1:0] rotr(input logic [W-1:0] d, input int a);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = d[(i + a) % W];
    return r;
  endfunction

  function automatic logic [W-1:0] rotl(input logic [W-1:0] d, input int a);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[(i + a) % W] = d[i];
    return r;
  endfunction

  function automatic logic [W-1:0] sra_exp(input logic [W-1:0] d, input int a);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = (i + a < W) ? d[i + a] : d[W-1];
    return r;
  endfunction

  task automatic test_reset_idle();
    apply(2'b00, '0, 0);
    check("R5 idle", '0);
  endtask

  task automatic test_sll();
    foreach (pats[p]) for (int a = 0; a < W; a++) begin
      logic [W-1:0] e;
      for (int i = 0; i < W; i++) e[i] = (i >= a) ? pats[p][i - a] : 1'b0;
      apply(2'b00, pats[p], a);
      check("R1", e);
    end
  endtask

  task automatic test_srl();
    foreach (pats[p]) for (int a = 0; a < W; a++) begin
      logic [W-1:0] e;
      for (int i = 0; i < W; i++) e[i] = (i + a < W) ? pats[p][i + a] : 1'b0;
      apply(2'b01, pats[p], a);
      check("R2", e);
    end
  endtask

  task automatic test_sra();
    foreach (pats[p]) for (int a = 0; a < W; a++) begin
      apply(2'b10, pats[p], a);
      check("R3", sra_exp(pats[p], a));
    end
  endtask

  task automatic test_ror();
    foreach (pats[p]) for (int a = 0; a < W; a++) begin
      apply(2'b11, pats[p], a);
      check("R4", rotr(pats[p], a));
    end
  endtask

  task automatic test_zero_amt();
    for (int o = 0; o < 4; o++) foreach (pats[p]) begin
      apply(2'(o), pats[p], 0);
      check("R5", pats[p]);
    end
  endtask

  task automatic test_sll_max();
    apply(2'b00, 32'hFFFF_FFFF, W - 1);
    check("R6", 32'h8000_0000);
    apply(2'b00, 32'hFFFF_FFFE, W - 1);
    check("R6", 32'h0000_0000);
  endtask

  task automatic test_sra_max();
    apply(2'b10, 32'h8000_0000, W - 1);
    check("R7", 32'hFFFF_FFFF);
    apply(2'b10, 32'h7FFF_FFFF, W - 1);
    check("R7", 32'h0000_0000);
  endtask

  task automatic test_rol_sw();
    foreach (pats[p]) for (int r = 0; r < W; r++) begin
      apply(2'b11, pats[p], (W - r) % W);
      check("R8", rotl(pats[p], r));
    end
  endtask

  initial begin
    op = 2'b00; data = '0; amt = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    test_reset_idle();
    test_sll();
    test_srl();
    test_sra();
    test_ror();
    test_zero_amt();
    test_sll_max();
    test_sra_max();
    test_rol_sw();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule